// File: doc/BRIEF.md
# Message-Signalled Interrupt Window Decoder

This block sits behind a write-only memory window that endpoint devices target when they raise message-signalled interrupts. The window is cut into 64 KiB slots, one per registered device entry. Each write's offset selects the slot, and the vector number is formed from both the offset and the data word. The offset contributes the word index within the slot, and the data word contributes its low bits. Both are OR-ed together, so address-encoded vectors (data zero) and data-encoded vectors (offset at the slot base) take the same decode path.

For each entry, a small table holds the first interrupt number given to that entry. A configuration port loads this table. The decoded vector is added to the entry's first number, and the result produces a one-clock pulse on that interrupt source. The pulse goes out both as a one-hot source vector and as a binary number, together with the slot index. A write that falls beyond the last entry is dropped and sets a sticky error flag. Reads of the window return zero and have no side effect.

Top module: `msi_window_decoder`

## Requirements
- R1: After reset, `irq_pulse`, `irq_vec`, `irq_num`, `irq_entry` and `err` are zero, and every entry's first interrupt number is zero.
- R2: The entry index of a write is `wr_offset >> 16`, i.e. bits [ADDR_W-1:16] of the offset. An accepted write reports this index on `irq_entry`.
- R3: The vector number is `(wr_offset[15:0] >> 2) | wr_data`. The interrupt number is `(first[entry] + vector) mod 2**IRQ_W` and appears on `irq_num`.
- R4: A write is accepted when `wr_en` is high, `rd_en` is low and the entry index is below ENTRIES. An accepted write raises `irq_pulse` for exactly one clock, on the clock edge that follows the write. Nothing else raises `irq_pulse`.
- R5: While `irq_pulse` is high, `irq_vec` has exactly one bit set, at position `irq_num`. At all other times `irq_vec` is zero.
- R6: A write whose entry index is ENTRIES or more produces no pulse. It sets `err` one clock later, and `err` then stays high until reset.
- R7: A cycle with `rd_en` high is a read. `rd_data` is zero, and no pulse is produced even if `wr_en` is also high. `err` is not changed.
- R8: When `cfg_we` is high, `cfg_base` is stored as the first interrupt number of entry `cfg_idx` (values of `cfg_idx` at or above ENTRIES are ignored). A window write in the same cycle uses the value stored before that cycle.
- R9: Writes on consecutive cycles each produce their own pulse, on consecutive cycles.
- R10: When there is no pulse, `irq_num` and `irq_entry` keep the values of the last accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Window write strobe |
| wr_offset | input | ADDR_W | Byte offset of the write within the window |
| wr_data | input | DATA_W | Write data word |
| rd_en | input | 1 | Window read strobe (takes precedence over a write) |
| rd_data | output | DATA_W | Read data, always zero |
| cfg_we | input | 1 | First-number table write strobe |
| cfg_idx | input | IDX_W | Table entry to load |
| cfg_base | input | IRQ_W | First interrupt number for that entry |
| irq_pulse | output | 1 | One-clock interrupt strobe |
| irq_vec | output | 2**IRQ_W | One-hot interrupt source pulses |
| irq_num | output | IRQ_W | Number of the signalled interrupt source |
| irq_entry | output | IDX_W | Entry index of the signalled write |
| err | output | 1 | Sticky out-of-range write flag |

## Verification
The bench builds the block with ENTRIES=6 and ADDR_W=19. This gives eight slot indices, so two valid-looking slots lie beyond the last entry, and the entry count is not a power of two. With IRQ_W=6 there are only 64 sources, so the sums wrap modulo 64 early and often. Together these bring the out-of-range drop, the sticky flag and the wrap of the addition within reach of both directed and pseudo-random writes.

// File: rtl/msi_window_decoder.sv
module msi_window_decoder #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int IRQ_W   = 8,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SLOT_W  = ADDR_W - 16,
  localparam int NUM_IRQ = 1 << IRQ_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_offset,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [IRQ_W-1:0]   cfg_base,
  output logic               irq_pulse,
  output logic [NUM_IRQ-1:0] irq_vec,
  output logic [IRQ_W-1:0]   irq_num,
  output logic [IDX_W-1:0]   irq_entry,
  output logic               err
);

  logic [IRQ_W-1:0]  first_q [ENTRIES];
  logic [SLOT_W-1:0] slot;
  logic [DATA_W-1:0] vec_full;
  logic [IRQ_W-1:0]  first_sel;
  logic [IRQ_W-1:0]  sum;
  logic              in_range, accept, drop;

  assign rd_data  = '0;
  assign slot     = wr_offset[ADDR_W-1:16];
  assign vec_full = DATA_W'(wr_offset[15:2]) | wr_data;
  assign in_range = 32'(slot) < ENTRIES;
  assign accept   = wr_en & ~rd_en & in_range;
  assign drop     = wr_en & ~rd_en & ~in_range;

  always_comb begin
    first_sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (32'(slot) == i) first_sel = first_q[i];
  end

  assign sum = first_sel + vec_full[IRQ_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) first_q[i] <= '0;
    end else if (cfg_we && 32'(cfg_idx) < ENTRIES) begin
      first_q[cfg_idx] <= cfg_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_vec   <= '0;
      irq_num   <= '0;
      irq_entry <= '0;
      err       <= 1'b0;
    end else begin
      irq_pulse <= accept;
      irq_vec   <= accept ? (NUM_IRQ'(1) << sum) : '0;
      if (accept) begin
        irq_num   <= sum;
        irq_entry <= slot[IDX_W-1:0];
      end
      if (drop) err <= 1'b1;
    end
  end

endmodule

// File: rtl/msi_window_decoder_chk.sv
module msi_window_decoder_chk #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 20,
  parameter int IRQ_W   = 8,
  localparam int NUM_IRQ = 1 << IRQ_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  wr_offset,
  input logic               irq_pulse,
  input logic [NUM_IRQ-1:0] irq_vec,
  input logic [IRQ_W-1:0]   irq_num,
  input logic               err
);

  logic hit_ok;
  logic hit_bad;
  assign hit_ok  = wr_en && !rd_en && (32'(wr_offset >> 16) < ENTRIES);
  assign hit_bad = wr_en && !rd_en && !(32'(wr_offset >> 16) < ENTRIES);

  // R4
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ok |=> irq_pulse);

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ok |=> !irq_pulse);

  // R5
  vec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (irq_vec[irq_num] && $countones(irq_vec) == 1));

  // R5
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> (irq_vec == '0));

  // R6
  oob_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_bad |=> (err && !irq_pulse));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R7
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !irq_pulse);

  // R10
  num_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> $stable(irq_num));

endmodule

bind msi_window_decoder msi_window_decoder_chk #(
  .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IRQ_W(IRQ_W)
) u_chk (.*);

// File: tb/sim_msi_window_decoder.sv
module sim_msi_window_decoder;
  localparam int ENTRIES = 6;
  localparam int ADDR_W  = 19;
  localparam int DATA_W  = 32;
  localparam int IRQ_W   = 6;
  localparam int IDX_W   = 3;
  localparam int NUM_IRQ = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, cfg_we = 1'b0;
  logic [ADDR_W-1:0]  wr_offset = '0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic [IDX_W-1:0]   cfg_idx = '0;
  logic [IRQ_W-1:0]   cfg_base = '0;
  logic [DATA_W-1:0]  rd_data;
  logic               irq_pulse;
  logic [NUM_IRQ-1:0] irq_vec;
  logic [IRQ_W-1:0]   irq_num;
  logic [IDX_W-1:0]   irq_entry;
  logic               err;

  always #10 clk = ~clk;

  msi_window_decoder #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_offset(wr_offset), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .irq_pulse(irq_pulse), .irq_vec(irq_vec), .irq_num(irq_num), .irq_entry(irq_entry), .err(err));

  int n_chk = 0;
  int n_bad = 0;
  int m_first [ENTRIES];
  bit e_pulse = 0;
  int e_num = 0;
  int e_entry = 0;
  bit e_err = 0;
  bit armed = 0;
  int lcg = 32'h1234_5678;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [NUM_IRQ-1:0] ev;
    ev = e_pulse ? (NUM_IRQ'(1) << e_num) : '0;
    check("R4 irq_pulse", irq_pulse, e_pulse);
    check(e_pulse ? "R3 irq_num" : "R10 irq_num", irq_num, e_num);
    check(e_pulse ? "R2 irq_entry" : "R10 irq_entry", irq_entry, e_entry);
    check("R5 irq_vec", irq_vec, ev);
    check("R6 err", err, e_err);
    check("R7 rd_data", rd_data, 0);
  endtask

  task automatic cyc(bit we, int off, int dat, bit re, bit cwe, int cidx, int cb);
    int idx, vec;
    @(negedge clk);
    if (armed) compare();
    wr_en = we; wr_offset = ADDR_W'(off); wr_data = dat; rd_en = re;
    cfg_we = cwe; cfg_idx = IDX_W'(cidx); cfg_base = IRQ_W'(cb);
    armed = 1;
    idx = (off & ((1 << ADDR_W) - 1)) >> 16;
    vec = ((off & 16'hFFFF) >> 2) | dat;
    e_pulse = 0;
    if (we && !re) begin
      if (idx < ENTRIES) begin
        e_pulse = 1;
        e_num = (m_first[idx] + vec) % NUM_IRQ;
        e_entry = idx;
      end else e_err = 1;
    end
    if (cwe && cidx < ENTRIES) m_first[cidx] = cb % NUM_IRQ;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < ENTRIES; i++) m_first[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 irq_pulse", irq_pulse, 0);
    check("R1 irq_vec", irq_vec, 0);
    check("R1 irq_num", irq_num, 0);
    check("R1 irq_entry", irq_entry, 0);
    check("R1 err", err, 0);
    rst_n = 1'b1;
    // R1: table reads zero before load
    cyc(1, (2 << 16), 3, 0, 0, 0, 0);
    idle();
    for (int i = 0; i < ENTRIES; i++) cyc(0, 0, 0, 0, 1, i, 5 + 9 * i);
    // R3: address-encoded vectors, data zero
    for (int e = 0; e < ENTRIES; e++) cyc(1, (e << 16) | ((e + 1) << 2), 0, 0, 0, 0, 0);
    idle();
    // R3: data-encoded vectors, offset at slot base
    for (int e = 0; e < ENTRIES; e++) cyc(1, (e << 16), e * 2 + 1, 0, 0, 0, 0);
    // R3: both sources merged by OR
    cyc(1, (1 << 16) | (4 << 2), 3, 0, 0, 0, 0);
    // R3: wrap modulo 64
    cyc(0, 0, 0, 0, 1, 3, 60);
    cyc(1, (3 << 16) | (10 << 2), 0, 0, 0, 0, 0);
    // R10: hold after pulse
    idle(); idle(); idle();
    // R7: read, alone and with a write
    cyc(0, 0, 0, 1, 0, 0, 0);
    cyc(1, (2 << 16), 1, 1, 0, 0, 0);
    cyc(1, (7 << 16), 1, 1, 0, 0, 0);
    idle();
    // R8: config and write to same entry in one cycle
    cyc(1, (4 << 16) | (2 << 2), 0, 0, 1, 4, 40);
    cyc(1, (4 << 16) | (2 << 2), 0, 0, 0, 0, 0);
    // R9: back-to-back pulses
    cyc(1, (0 << 16), 1, 0, 0, 0, 0);
    cyc(1, (5 << 16), 2, 0, 0, 0, 0);
    cyc(1, (0 << 16), 3, 0, 0, 0, 0);
    idle();
    // R6: out of range slots 6 and 7
    cyc(1, (6 << 16), 1, 0, 0, 0, 0);
    idle();
    cyc(1, (7 << 16) | 16'hFFFC, 0, 0, 0, 0, 0);
    cyc(1, (1 << 16), 2, 0, 0, 0, 0);
    idle();
    // R6: error survives valid traffic; mixed pseudo-random stream
    for (int k = 0; k < 400; k++) begin
      int off, dat, sel;
      lcg = lcg * 1103515245 + 12345;
      off = (lcg >>> 8) & 32'h7FFFF;
      lcg = lcg * 1103515245 + 12345;
      dat = (lcg >>> 12) & 32'h1F;
      sel = (lcg >>> 20) & 7;
      cyc(sel != 0, off, dat, sel == 7, sel == 3, (lcg >>> 4) & 7, (lcg >>> 24) & 63);
    end
    idle(); idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule